// File: doc/BRIEF.md
# Super I/O Configuration Register Controller

This block holds the plug-and-play configuration space of a legacy-PC multi-function I/O device. A host reaches it through a two-address I/O window. One address loads an 8-bit index. The other reads or writes the register that the index selects. The space stays closed until a key byte is written to the index address. After that the host can program the global registers, select a logical device, and set that device's enable, base address, IRQ, DMA and device-specific bytes.

Each logical device has its own bank of registers. Every bank drives resource outputs that the attached peripherals consume: enable, a 16-bit base, IRQ and DMA. A bank also raises a one-cycle change pulse after each accepted write, so a peripheral can re-map itself. The control register can close the window again or restore every default. A sticky software lock freezes two of the global registers until the next reset.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: After reset the window is closed. While it is closed:
  - A write of 0x87 to the index address (0x2E) opens it. Any other byte written there leaves it closed.
  - Writes to the data address (0x2F) are ignored.
  - Reads of either address return 0xFF.
- R2: While open, a write to 0x2E loads the index and a read of 0x2E returns it. The index persists when the window is closed and reopened.
- R3: Index 0x02 is write-only and reads 0xFF. Writing it with bit 1 set closes the window. Writing it with bit 0 set restores every register to its reset value, which also closes the window and clears the index.
- R4: Index 0x07 holds the logical device number and reads back. Each device below 11 has its own copy of these registers:
  - 0x30: enable, bit 0 only.
  - 0x60..0x63: base bytes, 8 bits each.
  - 0x70: IRQ, low 4 bits.
  - 0x74: DMA, low 4 bits.
  - 0xF0..0xFF: device-specific bytes, 8 bits each.
- R5: While the device number is 11 or more, writes to the banked indexes are ignored and reads of them return 0xFF.
- R6: Index 0x23 stores the written value AND 0xD9. Index 0x24 always reads 0x00. Index 0x2C stores the written value AND 0x1C.
- R7: Indexes 0x25..0x2A accept writes only while the device number is 7. Indexes 0x25..0x28 store all 8 bits. Index 0x29 stores the value AND 0x3F, and 0x2A stores the value AND 0x7F.
- R8: Index 0x2B accepts a write only while its stored bit 7 is clear. Once a value with bit 7 set is stored, writes to 0x23 and 0x2B are ignored until a reset.
- R9: The reset state is as follows:
  - The window is closed and the device number is 0.
  - Indexes 0x20, 0x21 and 0x22 read 0x87, 0x02 and 0x07.
  - Device 0 has base 0x03F0, IRQ 6 and DMA 2.
  - Device 1 has base 0x0378, IRQ 7 and DMA 3.
  - Device 2 has base 0x02F8 and IRQ 4. Device 3 has base 0x0278 and IRQ 4.
  - All devices are disabled, and every other banked field is 0.
- R10: Reads of unimplemented indexes (for example 0x00 and 0x2D) and of any other I/O address return 0xFF.
- R11: For each device d, the outputs are:
  - `dev_en_o[d]`: its enable.
  - `dev_base_o[16*d +: 16]`: {byte 0x60, byte 0x61}.
  - `dev_irq_o[4*d +: 4]`: its IRQ.
  - `dev_dma_o[4*d +: 4]`: its DMA.
  Each output shows a new value from the clock edge that accepts the write.
- R12: `dev_chg_o[d]` is high for exactly the one cycle after an accepted write to a banked register of device d. No other bit rises with it, and ignored writes raise no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_wr_i | input | 1 | Single-cycle write strobe |
| io_rdata_o | output | 8 | Read data, combinational from address, index and device number |
| cfg_open_o | output | 1 | Configuration window open |
| dev_en_o | output | 11 | Per-device enable |
| dev_base_o | output | 176 | Per-device 16-bit base |
| dev_irq_o | output | 44 | Per-device IRQ |
| dev_dma_o | output | 44 | Per-device DMA |
| dev_chg_o | output | 11 | Per-device change pulse |

## Verification
A wrong device number or bank select shows up in the first read of a banked index. It shows up sooner on the resource outputs and change pulses, where the wrong device's bits move on the cycle after the write. A lock or index fault shows as 0xFF, or a stale value, on the very next window read. A soft reset that misses a register is caught when the defaults are read back after reopening. A software lock that leaks is caught by reading 0x23 or 0x2B back after the frozen write.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] IDX_CTRL = 8'h02;
  localparam logic [7:0] IDX_LDN  = 8'h07;
  localparam logic [7:0] IDX_ID0  = 8'h20;
  localparam logic [7:0] IDX_ID1  = 8'h21;
  localparam logic [7:0] IDX_ID2  = 8'h22;
  localparam logic [7:0] IDX_G23  = 8'h23;
  localparam logic [7:0] IDX_G24  = 8'h24;
  localparam logic [7:0] IDX_GX0  = 8'h25;
  localparam logic [7:0] IDX_GX5  = 8'h2A;
  localparam logic [7:0] IDX_SWL  = 8'h2B;
  localparam logic [7:0] IDX_G2C  = 8'h2C;
  localparam logic [7:0] IDX_EN   = 8'h30;
  localparam logic [7:0] IDX_IRQ  = 8'h70;
  localparam logic [7:0] IDX_DMA  = 8'h74;

  localparam logic [7:0] ID_B0 = 8'h87;
  localparam logic [7:0] ID_B1 = 8'h02;
  localparam logic [7:0] ID_B2 = 8'h07;

  localparam logic [7:0] GX_LDN = 8'd7;

  function automatic logic is_banked(logic [7:0] idx);
    return (idx == IDX_EN) || (idx[7:2] == 6'b0110_00) ||
           (idx == IDX_IRQ) || (idx == IDX_DMA) || (idx[7:4] == 4'hF);
  endfunction

  function automatic logic [7:0] gx_mask(logic [7:0] idx);
    case (idx)
      8'h29:   return 8'h3F;
      8'h2A:   return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [15:0] dflt_base(int unsigned d);
    case (d)
      0:       return 16'h03F0;
      1:       return 16'h0378;
      2:       return 16'h02F8;
      3:       return 16'h0278;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [3:0] dflt_irq(int unsigned d);
    case (d)
      0:       return 4'd6;
      1:       return 4'd7;
      2, 3:    return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] dflt_dma(int unsigned d);
    case (d)
      0:       return 4'd2;
      1:       return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] IDX_ADDR  = 16'h002E,
  parameter logic [15:0] DATA_ADDR = 16'h002F,
  parameter logic [7:0]  KEY       = 8'h87,
  parameter int unsigned NUM_DEV   = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  output logic              open_o,
  output logic [7:0]        index_o,
  output logic [7:0]        ldn_o,
  output logic [7:0]        glob_rdata_o,
  output logic              bank_we_o,
  output logic              soft_rst_o
);

  localparam int unsigned NUM_GX = 6;

  logic       open_q;
  logic [7:0] index_q, ldn_q, g23_q, g2b_q, g2c_q;
  logic [7:0] gx_q [NUM_GX];
  logic       idx_wr, dat_wr, soft_rst, swlock, gx_hit;

  assign idx_wr   = wr_i && (addr_i == ADDR_W'(IDX_ADDR));
  assign dat_wr   = wr_i && (addr_i == ADDR_W'(DATA_ADDR)) && open_q;
  assign soft_rst = dat_wr && (index_q == IDX_CTRL) && wdata_i[0];
  assign swlock   = g2b_q[7];
  assign gx_hit   = (index_q >= IDX_GX0) && (index_q <= IDX_GX5);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      index_q <= '0;
      ldn_q   <= '0;
      g23_q   <= '0;
      g2b_q   <= '0;
      g2c_q   <= '0;
      for (int i = 0; i < NUM_GX; i++) gx_q[i] <= '0;
    end else if (soft_rst) begin
      open_q  <= 1'b0;
      index_q <= '0;
      ldn_q   <= '0;
      g23_q   <= '0;
      g2b_q   <= '0;
      g2c_q   <= '0;
      for (int i = 0; i < NUM_GX; i++) gx_q[i] <= '0;
    end else begin
      if (idx_wr) begin
        if (open_q)              index_q <= wdata_i;
        else if (wdata_i == KEY) open_q  <= 1'b1;
      end
      if (dat_wr) begin
        if (index_q == IDX_CTRL && wdata_i[1]) open_q <= 1'b0;
        if (index_q == IDX_LDN) ldn_q <= wdata_i;
        if (index_q == IDX_G23 && !swlock) g23_q <= wdata_i & 8'hD9;
        if (index_q == IDX_SWL && !swlock) g2b_q <= wdata_i;
        if (index_q == IDX_G2C) g2c_q <= wdata_i & 8'h1C;
        if (gx_hit && ldn_q == GX_LDN)
          gx_q[3'(index_q - IDX_GX0)] <= wdata_i & gx_mask(index_q);
      end
    end
  end

  always_comb begin
    glob_rdata_o = 8'hFF;
    if (gx_hit) glob_rdata_o = gx_q[3'(index_q - IDX_GX0)];
    else begin
      case (index_q)
        IDX_LDN: glob_rdata_o = ldn_q;
        IDX_ID0: glob_rdata_o = ID_B0;
        IDX_ID1: glob_rdata_o = ID_B1;
        IDX_ID2: glob_rdata_o = ID_B2;
        IDX_G23: glob_rdata_o = g23_q;
        IDX_G24: glob_rdata_o = 8'h00;
        IDX_SWL: glob_rdata_o = g2b_q;
        IDX_G2C: glob_rdata_o = g2c_q;
        default: glob_rdata_o = 8'hFF;
      endcase
    end
  end

  assign open_o     = open_q;
  assign index_o    = index_q;
  assign ldn_o      = ldn_q;
  assign soft_rst_o = soft_rst;
  assign bank_we_o  = dat_wr && is_banked(index_q) && (ldn_q < 8'(NUM_DEV));

  assert_key_unlock_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && idx_wr && wdata_i == KEY) |=> open_q);

  assert_closed_frozen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q |=> ($stable(index_q) && $stable(ldn_q) && $stable(g23_q)));

  assert_relock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && index_q == IDX_CTRL && wdata_i[1]) |=> !open_q);

  assert_soft_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (!open_q && ldn_q == 8'd0 && index_q == 8'd0));

  assert_swlock_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swlock && !soft_rst) |=> ($stable(g23_q) && $stable(g2b_q)));

endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
  import sio_cfg_pkg::*;
#(
  parameter int unsigned DEV = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        we_i,
  input  logic [7:0]  idx_i,
  input  logic [7:0]  wdata_i,
  output logic        en_o,
  output logic [15:0] base_o,
  output logic [3:0]  irq_o,
  output logic [3:0]  dma_o,
  output logic [7:0]  rdata_o,
  output logic        chg_o
);

  localparam logic [15:0] BASE_RST = dflt_base(DEV);
  localparam logic [3:0]  IRQ_RST  = dflt_irq(DEV);
  localparam logic [3:0]  DMA_RST  = dflt_dma(DEV);

  logic       en_q, chg_q;
  logic [3:0] irq_q, dma_q;
  logic [7:0] base_q [4];
  logic [7:0] spec_q [16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      chg_q <= 1'b0;
      irq_q <= IRQ_RST;
      dma_q <= DMA_RST;
      base_q[0] <= BASE_RST[15:8];
      base_q[1] <= BASE_RST[7:0];
      base_q[2] <= '0;
      base_q[3] <= '0;
      for (int i = 0; i < 16; i++) spec_q[i] <= '0;
    end else if (clr_i) begin
      en_q  <= 1'b0;
      chg_q <= 1'b0;
      irq_q <= IRQ_RST;
      dma_q <= DMA_RST;
      base_q[0] <= BASE_RST[15:8];
      base_q[1] <= BASE_RST[7:0];
      base_q[2] <= '0;
      base_q[3] <= '0;
      for (int i = 0; i < 16; i++) spec_q[i] <= '0;
    end else begin
      chg_q <= we_i;
      if (we_i) begin
        if (idx_i == IDX_EN)               en_q <= wdata_i[0];
        else if (idx_i[7:2] == 6'b0110_00) base_q[idx_i[1:0]] <= wdata_i;
        else if (idx_i == IDX_IRQ)         irq_q <= wdata_i[3:0];
        else if (idx_i == IDX_DMA)         dma_q <= wdata_i[3:0];
        else if (idx_i[7:4] == 4'hF)       spec_q[idx_i[3:0]] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = 8'hFF;
    if (idx_i == IDX_EN)               rdata_o = {7'd0, en_q};
    else if (idx_i[7:2] == 6'b0110_00) rdata_o = base_q[idx_i[1:0]];
    else if (idx_i == IDX_IRQ)         rdata_o = {4'd0, irq_q};
    else if (idx_i == IDX_DMA)         rdata_o = {4'd0, dma_q};
    else if (idx_i[7:4] == 4'hF)       rdata_o = spec_q[idx_i[3:0]];
  end

  assign en_o   = en_q;
  assign base_o = {base_q[0], base_q[1]};
  assign irq_o  = irq_q;
  assign dma_o  = dma_q;
  assign chg_o  = chg_q;

  assert_clr_defaults_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!en_o && base_o == BASE_RST && irq_o == IRQ_RST && dma_o == DMA_RST && !chg_o));

endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] IDX_ADDR  = 16'h002E,
  parameter logic [15:0] DATA_ADDR = 16'h002F,
  parameter logic [7:0]  KEY       = 8'h87,
  parameter int unsigned NUM_DEV   = 11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     io_addr_i,
  input  logic [7:0]            io_wdata_i,
  input  logic                  io_wr_i,
  output logic [7:0]            io_rdata_o,
  output logic                  cfg_open_o,
  output logic [NUM_DEV-1:0]    dev_en_o,
  output logic [NUM_DEV*16-1:0] dev_base_o,
  output logic [NUM_DEV*4-1:0]  dev_irq_o,
  output logic [NUM_DEV*4-1:0]  dev_dma_o,
  output logic [NUM_DEV-1:0]    dev_chg_o
);

  logic       open, bank_we, soft_rst;
  logic [7:0] index, ldn, glob_rdata, bank_sel_rd;
  logic [7:0] bank_rd [NUM_DEV];

  sio_cfg_port #(
    .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR),
    .KEY(KEY), .NUM_DEV(NUM_DEV)
  ) i_port (
    .clk_i, .rst_ni,
    .addr_i       (io_addr_i),
    .wdata_i      (io_wdata_i),
    .wr_i         (io_wr_i),
    .open_o       (open),
    .index_o      (index),
    .ldn_o        (ldn),
    .glob_rdata_o (glob_rdata),
    .bank_we_o    (bank_we),
    .soft_rst_o   (soft_rst)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    sio_cfg_bank #(.DEV(d)) i_bank (
      .clk_i, .rst_ni,
      .clr_i   (soft_rst),
      .we_i    (bank_we && ldn == 8'(d)),
      .idx_i   (index),
      .wdata_i (io_wdata_i),
      .en_o    (dev_en_o[d]),
      .base_o  (dev_base_o[16*d +: 16]),
      .irq_o   (dev_irq_o[4*d +: 4]),
      .dma_o   (dev_dma_o[4*d +: 4]),
      .rdata_o (bank_rd[d]),
      .chg_o   (dev_chg_o[d])
    );
  end

  always_comb begin
    bank_sel_rd = 8'hFF;
    for (int d = 0; d < NUM_DEV; d++)
      if (ldn == 8'(d)) bank_sel_rd = bank_rd[d];
  end

  always_comb begin
    io_rdata_o = 8'hFF;
    if (open) begin
      if (io_addr_i == ADDR_W'(IDX_ADDR))       io_rdata_o = index;
      else if (io_addr_i == ADDR_W'(DATA_ADDR)) io_rdata_o = is_banked(index) ? bank_sel_rd : glob_rdata;
    end
  end

  assign cfg_open_o = open;

  assert_chg_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_chg_o));

  assert_bad_ldn_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == ADDR_W'(DATA_ADDR) && ldn >= 8'(NUM_DEV)) |=> (dev_chg_o == '0));

  assert_closed_no_chg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open && io_wr_i) |=> (dev_chg_o == '0));

endmodule

// File: tb/test_sio_cfg_ctrl.sv
module test_sio_cfg_ctrl;

  localparam int CLK_P = 10;
  localparam int ND    = 11;
  localparam logic [15:0] IA = 16'h002E;
  localparam logic [15:0] DA = 16'h002F;

  localparam int K_RD = 0, K_CHG = 1, K_EN = 2, K_BASE = 3, K_IRQ = 4, K_DMA = 5;

  typedef struct {
    int    kind;
    int    dev;
    int    exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic        cfg_open;
  logic [ND-1:0]    dev_en, dev_chg;
  logic [ND*16-1:0] dev_base;
  logic [ND*4-1:0]  dev_irq, dev_dma;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  item_t q[$];

  always #(CLK_P/2) clk = ~clk;

  sio_cfg_ctrl i_sio_cfg_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_wr_i(io_wr),
    .io_rdata_o(io_rdata), .cfg_open_o(cfg_open),
    .dev_en_o(dev_en), .dev_base_o(dev_base), .dev_irq_o(dev_irq),
    .dev_dma_o(dev_dma), .dev_chg_o(dev_chg)
  );

  // monitor: compares queued expectations half a cycle after they are posted
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = int'(io_rdata);
        K_CHG:   act = int'(dev_chg);
        K_EN:    act = int'(dev_en);
        K_BASE:  act = int'(dev_base[16*it.dev +: 16]);
        K_IRQ:   act = int'(dev_irq[4*it.dev +: 4]);
        default: act = int'(dev_dma[4*it.dev +: 4]);
      endcase
      checks++;
      if (act != it.exp) begin
        fails++;
        $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(int kind, int dev, int exp, string tag);
    item_t it;
    it.kind = kind; it.dev = dev; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drv_wr(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0; io_addr = '0;
  endtask

  task automatic chk_rd(logic [15:0] a, int exp, string tag);
    @(posedge clk); #1;
    io_addr = a;
    push(K_RD, 0, exp, tag);
  endtask

  task automatic chk_out(int kind, int dev, int exp, string tag);
    @(posedge clk); #1;
    push(kind, dev, exp, tag);
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    drv_wr(IA, idx);
    drv_wr(DA, d);
  endtask

  // write, then expect the change-pulse vector in the following cycle
  task automatic reg_wr_chg(logic [7:0] idx, logic [7:0] d, int exp_chg, string tag);
    reg_wr(idx, d);
    push(K_CHG, 0, exp_chg, tag);
  endtask

  task automatic reg_rd(logic [7:0] idx, int exp, string tag);
    drv_wr(IA, idx);
    chk_rd(DA, exp, tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R9 / R11 reset state
    chk_out(K_BASE, 0, 16'h03F0, "R9 dev0 base");
    chk_out(K_IRQ,  0, 6, "R9 dev0 irq");
    chk_out(K_DMA,  0, 2, "R9 dev0 dma");
    chk_out(K_BASE, 1, 16'h0378, "R9 dev1 base");
    chk_out(K_IRQ,  1, 7, "R9 dev1 irq");
    chk_out(K_DMA,  1, 3, "R9 dev1 dma");
    chk_out(K_BASE, 2, 16'h02F8, "R9 dev2 base");
    chk_out(K_IRQ,  2, 4, "R9 dev2 irq");
    chk_out(K_BASE, 3, 16'h0278, "R9 dev3 base");
    chk_out(K_IRQ,  3, 4, "R9 dev3 irq");
    chk_out(K_EN,   0, 0, "R9 all disabled");
    chk_rd(IA, 8'hFF, "R1 closed index read");

    // R1 key handling
    drv_wr(IA, 8'h55);
    chk_rd(IA, 8'hFF, "R1 wrong key stays closed");
    drv_wr(DA, 8'h01);
    chk_rd(DA, 8'hFF, "R1 closed data read");
    drv_wr(IA, 8'h87);
    chk_rd(IA, 8'h00, "R2 index after open");

    // R9 ids, R3 control, R10 unimplemented
    reg_rd(8'h20, 8'h87, "R9 id0");
    reg_rd(8'h21, 8'h02, "R9 id1");
    reg_rd(8'h22, 8'h07, "R9 id2");
    reg_rd(8'h02, 8'hFF, "R3 control write-only");
    reg_rd(8'h00, 8'hFF, "R10 idx 00");
    reg_rd(8'h2D, 8'hFF, "R10 idx 2D");
    chk_rd(16'h0080, 8'hFF, "R10 foreign address");
    chk_rd(IA, 8'h2D, "R2 index readback");

    // R4 / R11 / R12 banked access on device 1
    reg_wr(8'h07, 8'h01);
    reg_rd(8'h07, 8'h01, "R4 ldn readback");
    reg_wr_chg(8'h60, 8'h12, 11'h002, "R12 chg dev1 base hi");
    reg_wr_chg(8'h61, 8'h34, 11'h002, "R12 chg dev1 base lo");
    chk_out(K_BASE, 1, 16'h1234, "R11 dev1 base out");
    reg_wr(8'h70, 8'hFB);
    reg_rd(8'h70, 8'h0B, "R4 irq low nibble");
    chk_out(K_IRQ, 1, 4'hB, "R11 dev1 irq out");
    reg_wr(8'h30, 8'hFF);
    reg_rd(8'h30, 8'h01, "R4 enable bit0");
    chk_out(K_EN, 0, 11'h002, "R11 en vector");
    reg_wr(8'hF5, 8'hA5);
    reg_rd(8'hF5, 8'hA5, "R4 specific byte");
    reg_wr(8'h63, 8'h9C);
    reg_rd(8'h63, 8'h9C, "R4 base byte 3");

    // device 3 isolation
    reg_wr(8'h07, 8'h03);
    reg_wr_chg(8'h74, 8'h37, 11'h008, "R12 chg dev3 dma");
    chk_out(K_DMA, 3, 7, "R11 dev3 dma out");
    reg_rd(8'h70, 8'h04, "R4 dev3 irq untouched");
    reg_rd(8'hF5, 8'h00, "R4 dev3 specific separate");

    // R5 out-of-range device
    reg_wr(8'h07, 8'h0B);
    reg_wr_chg(8'h30, 8'h01, 11'h000, "R5 no chg for ldn 11");
    chk_out(K_EN, 0, 11'h002, "R5 enable vector unchanged");
    reg_rd(8'h30, 8'hFF, "R5 banked read ldn 11");
    reg_wr(8'h07, 8'h0A);
    reg_wr_chg(8'h70, 8'h05, 11'h400, "R12 chg dev10");
    chk_out(K_IRQ, 10, 5, "R11 dev10 irq out");

    // R7 gated globals
    reg_wr(8'h07, 8'h00);
    reg_wr_chg(8'h25, 8'h11, 11'h000, "R12 global write no chg");
    reg_rd(8'h25, 8'h00, "R7 ignored when ldn!=7");
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h25, 8'h11);
    reg_rd(8'h25, 8'h11, "R7 0x25 with ldn 7");
    reg_wr(8'h28, 8'hC3);
    reg_rd(8'h28, 8'hC3, "R7 0x28 with ldn 7");
    reg_wr(8'h29, 8'hFF);
    reg_rd(8'h29, 8'h3F, "R7 0x29 mask");
    reg_wr(8'h2A, 8'hFF);
    reg_rd(8'h2A, 8'h7F, "R7 0x2A mask");

    // R6 masks
    reg_wr(8'h23, 8'hFF);
    reg_rd(8'h23, 8'hD9, "R6 0x23 mask");
    reg_wr(8'h24, 8'hFF);
    reg_rd(8'h24, 8'h00, "R6 0x24 zero");
    reg_wr(8'h2C, 8'hFF);
    reg_rd(8'h2C, 8'h1C, "R6 0x2C mask");

    // R8 software lock
    reg_wr(8'h2B, 8'h05);
    reg_rd(8'h2B, 8'h05, "R8 unlocked write");
    reg_wr(8'h2B, 8'h83);
    reg_rd(8'h2B, 8'h83, "R8 lock set");
    reg_wr(8'h2B, 8'h00);
    reg_rd(8'h2B, 8'h83, "R8 0x2B frozen");
    reg_wr(8'h23, 8'h00);
    reg_rd(8'h23, 8'hD9, "R8 0x23 frozen");

    // R3 relock, R1 closed writes ignored, R2 index kept
    reg_wr(8'h02, 8'h02);
    chk_rd(IA, 8'hFF, "R3 relocked");
    drv_wr(DA, 8'h01);
    drv_wr(IA, 8'h87);
    chk_rd(IA, 8'h02, "R2 index kept across lock");
    reg_rd(8'h07, 8'h07, "R1 closed data write ignored");
    reg_rd(8'h2B, 8'h83, "R1 lock state kept");

    // R3 soft reset
    reg_wr(8'h02, 8'h01);
    chk_rd(IA, 8'hFF, "R3 soft reset closes");
    chk_out(K_BASE, 1, 16'h0378, "R3 dev1 base default");
    chk_out(K_IRQ, 1, 7, "R3 dev1 irq default");
    chk_out(K_DMA, 3, 0, "R3 dev3 dma default");
    chk_out(K_EN, 0, 0, "R3 enables cleared");
    drv_wr(IA, 8'h87);
    chk_rd(IA, 8'h00, "R3 index cleared");
    reg_rd(8'h07, 8'h00, "R3 ldn cleared");
    reg_rd(8'h2B, 8'h00, "R3 sw lock cleared");
    reg_wr(8'h23, 8'hFF);
    reg_rd(8'h23, 8'hD9, "R8 0x23 writable after reset");
    reg_rd(8'hF5, 8'h00, "R3 specific default");

    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule